// File: doc/BRIEF.md
# Video RAM Block-Copy DMA Controller

This block copies data from a 16-bit system address space into video RAM in chunks of 16 bytes. Software programs a source pointer, a destination pointer and a chunk count through five byte-wide registers. The transfer then runs in one of two modes. In general-purpose mode the whole length is copied back to back while the CPU is held. In horizontal-blank mode one chunk is copied each time the display enters horizontal blanking, and software may cancel the rest of the transfer between chunks.

The block has a read port with a one-cycle latency toward the source memory and a write port into video RAM. Each byte is read in one cycle and written in the next. A CPU-halt output is high only while a chunk is actually being moved. A status read returns an idle/busy flag together with the number of chunks still to go.

The controller is built around four named states. `S_IDLE` waits for a control write. `S_ARMED` waits for a qualified blanking pulse. `S_BURST` issues the 16 source reads of a chunk. `S_FLUSH` writes the last byte and steps to the next chunk. The transitions are:
- start-general: `S_IDLE` to `S_BURST`.
- start-hblank: `S_IDLE` to `S_ARMED`.
- blank-hit: `S_ARMED` to `S_BURST`.
- cancel: `S_ARMED` to `S_IDLE`.
- last-read: `S_BURST` to `S_FLUSH`.
- next-chunk: `S_FLUSH` to `S_BURST` in general-purpose mode.
- wait-line: `S_FLUSH` to `S_ARMED` in horizontal-blank mode.
- finish: `S_FLUSH` to `S_IDLE` once the count is exhausted.

Top module: `vram_blkcopy`

## Requirements
- R1: Register index 0 supplies source address bits 15..8, and bits 7..4 of index 1 supply source bits 7..4. Source bits 3..0 start at zero, whatever was written to bits 3..0 of index 1.
- R2: Bits 4..0 of index 2 supply video RAM offset bits 12..8, and bits 7..4 of index 3 supply offset bits 7..4. Offset bits 3..0 start at zero. Bits 7..5 of index 2 are ignored, and the 13-bit offset wraps from 0x1FFF to 0x0000.
- R3: A write of value C to index 4 transfers (C[6:0]+1)*16 bytes. Source and destination advance by one per byte, and this continues across chunk boundaries.
- R4: In the idle state, a write to index 4 with bit 7 = 0 starts general-purpose mode on the next cycle. Chunks run back to back, and `cpu_halt` is high for exactly 17 cycles per chunk.
- R5: In the idle state, a write to index 4 with bit 7 = 1 arms horizontal-blank mode. No byte moves until an `hblank_pulse` arrives while `disp_en` is 1, and each such pulse moves exactly 16 bytes.
- R6: An `hblank_pulse` that arrives while `disp_en` is 0 moves nothing.
- R7: While armed between chunks, a write to index 4 with bit 7 = 0 cancels the transfer. Later pulses move nothing, and the status reads bit 7 = 1 with bits 6..0 unchanged.
- R8: Reading index 4 returns bit 7 = 0 while a transfer is active and 1 otherwise. Bits 6..0 hold the remaining chunk count minus one, which is 0x7F after completion and after reset. Other indices read 0xFF.
- R9: `cpu_halt` is high only while a chunk is being copied. It is low while armed and waiting for blanking, and every video RAM write occurs with `cpu_halt` high.
- R10: Every source read is followed in the next cycle by a video RAM write of the returned byte, to the matching offset.
- R11: Writes to indices 0 to 3, and writes to index 4 with bit 7 = 1, are ignored while a transfer is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index 0..4 |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the selected index |
| hblank_pulse | input | 1 | One-cycle pulse at the start of horizontal blanking |
| disp_en | input | 1 | Display enabled |
| src_rd | output | 1 | Source read request |
| src_addr | output | 16 | Source byte address |
| src_data | input | 8 | Source byte, valid the cycle after `src_rd` |
| vram_we | output | 1 | Video RAM write strobe |
| vram_addr | output | 13 | Video RAM byte offset |
| vram_wdata | output | 8 | Video RAM write data |
| cpu_halt | output | 1 | CPU hold during chunk copy |

## Verification
General-purpose transfers are swept over every chunk count from 1 to 32 and also the maximum of 128. Each run uses a different source and destination. Junk is written into the ignored low nibble and the ignored high destination bits, which separates correct field slicing from sloppy slicing. The largest run starts just below the top of both address spaces, so pointer wrap and cross-chunk carry are exercised. The per-byte address/data comparison separates source faults from destination faults, and the halt-cycle count catches pacing errors. The blanking-mode sequence covers the following patterns, each of which separates one gating fault from the others:
- a pulse with the display off;
- pointer writes while armed;
- a cancel with one chunk left;
- a single-chunk transfer run to completion.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ARMED,
        S_BURST,
        S_FLUSH
    } vbc_state_e;

    localparam logic [2:0] RA_SRC_HI = 3'd0;
    localparam logic [2:0] RA_SRC_LO = 3'd1;
    localparam logic [2:0] RA_DST_HI = 3'd2;
    localparam logic [2:0] RA_DST_LO = 3'd3;
    localparam logic [2:0] RA_CTRL   = 3'd4;

endpackage

// File: rtl/vbc_regs.sv
module vbc_regs
    import vbc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int VRAM_W     = 13,
    parameter int CHUNK_LOG2 = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [2:0]                   addr,
    input  logic [7:0]                   wdata,
    input  logic                         busy,
    output logic [ADDR_W-CHUNK_LOG2-1:0] src_base,
    output logic [VRAM_W-CHUNK_LOG2-1:0] dst_base
);

    localparam int SRC_HI_W = ADDR_W - 8;
    localparam int DST_HI_W = VRAM_W - 8;
    localparam int LO_W     = 8 - CHUNK_LOG2;

    logic [SRC_HI_W-1:0] src_hi_q;
    logic [LO_W-1:0]     src_lo_q;
    logic [DST_HI_W-1:0] dst_hi_q;
    logic [LO_W-1:0]     dst_lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_hi_q <= '0;
            src_lo_q <= '0;
            dst_hi_q <= '0;
            dst_lo_q <= '0;
        end else if (we && !busy) begin
            case (addr)
                RA_SRC_HI: src_hi_q <= wdata[SRC_HI_W-1:0];
                RA_SRC_LO: src_lo_q <= wdata[7:CHUNK_LOG2];
                RA_DST_HI: dst_hi_q <= wdata[DST_HI_W-1:0];
                RA_DST_LO: dst_lo_q <= wdata[7:CHUNK_LOG2];
                default:   ;
            endcase
        end
    end

    assign src_base = {src_hi_q, src_lo_q};
    assign dst_base = {dst_hi_q, dst_lo_q};

    // R11
    ptr_regs_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(src_base) && $stable(dst_base)));

endmodule

// File: rtl/vbc_ptr.sv
module vbc_ptr #(
    parameter int ADDR_W     = 16,
    parameter int VRAM_W     = 13,
    parameter int CHUNK_LOG2 = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic                         step,
    input  logic                         adv,
    input  logic [ADDR_W-CHUNK_LOG2-1:0] src_base,
    input  logic [VRAM_W-CHUNK_LOG2-1:0] dst_base,
    output logic                         src_rd,
    output logic [ADDR_W-1:0]            src_addr,
    output logic                         vram_we,
    output logic [VRAM_W-1:0]            vram_addr,
    output logic                         last_byte
);

    logic [ADDR_W-CHUNK_LOG2-1:0] src_q;
    logic [VRAM_W-CHUNK_LOG2-1:0] dst_q;
    logic [CHUNK_LOG2-1:0]        idx_q;
    logic                         wr_v_q;
    logic [VRAM_W-1:0]            wr_a_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            idx_q  <= '0;
            wr_v_q <= 1'b0;
            wr_a_q <= '0;
        end else begin
            wr_v_q <= step;
            if (step) begin
                wr_a_q <= {dst_q, idx_q};
                idx_q  <= idx_q + 1'b1;
            end
            if (load) begin
                src_q <= src_base;
                dst_q <= dst_base;
                idx_q <= '0;
            end else if (adv) begin
                src_q <= src_q + 1'b1;
                dst_q <= dst_q + 1'b1;
            end
        end
    end

    assign src_rd    = step;
    assign src_addr  = {src_q, idx_q};
    assign vram_we   = wr_v_q;
    assign vram_addr = wr_a_q;
    assign last_byte = &idx_q;

    // R10
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd |=> (vram_we && vram_addr[CHUNK_LOG2-1:0] == $past(src_addr[CHUNK_LOG2-1:0])));

endmodule

// File: rtl/vbc_fsm.sv
module vbc_fsm
    import vbc_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [7:0]       ctrl_wdata,
    input  logic             hblank_i,
    input  logic             disp_en_i,
    input  logic             last_byte,
    output logic             load,
    output logic             step,
    output logic             adv,
    output logic             busy,
    output logic             halt,
    output logic [LEN_W-1:0] remaining
);

    vbc_state_e       state_q, state_d;
    logic             hb_q, hb_d;
    logic [LEN_W-1:0] len_q, len_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            hb_q    <= 1'b0;
            len_q   <= '1;
        end else begin
            state_q <= state_d;
            hb_q    <= hb_d;
            len_q   <= len_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        hb_d    = hb_q;
        len_d   = len_q;
        unique case (state_q)
            S_IDLE: begin
                if (ctrl_we) begin
                    len_d   = ctrl_wdata[LEN_W-1:0];
                    hb_d    = ctrl_wdata[7];
                    state_d = ctrl_wdata[7] ? S_ARMED : S_BURST;
                end
            end
            S_ARMED: begin
                if (ctrl_we && !ctrl_wdata[7]) begin
                    hb_d    = 1'b0;
                    state_d = S_IDLE;
                end else if (hblank_i && disp_en_i) begin
                    state_d = S_BURST;
                end
            end
            S_BURST: begin
                if (last_byte) state_d = S_FLUSH;
            end
            S_FLUSH: begin
                len_d = len_q - 1'b1;
                if (len_q == '0)  state_d = S_IDLE;
                else if (hb_q)    state_d = S_ARMED;
                else              state_d = S_BURST;
            end
        endcase
    end

    // outputs
    always_comb begin
        load = (state_q == S_IDLE) && ctrl_we;
        step = (state_q == S_BURST);
        adv  = (state_q == S_FLUSH);
        busy = (state_q != S_IDLE);
        halt = (state_q == S_BURST) || (state_q == S_FLUSH);
    end

    assign remaining = len_q;

    // R5 R6
    blank_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BURST && $past(state_q) == S_ARMED) |-> $past(hblank_i && disp_en_i));

    // R3
    last_chunk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && len_q == '0) |=> (state_q == S_IDLE));

    // R7
    cancel_keeps_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ARMED && ctrl_we && !ctrl_wdata[7]) |=> (!busy && len_q == $past(len_q)));

endmodule

// File: rtl/vram_blkcopy.sv
module vram_blkcopy
    import vbc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int VRAM_W     = 13,
    parameter int LEN_W      = 7,
    parameter int CHUNK_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              hblank_pulse,
    input  logic              disp_en,
    output logic              src_rd,
    output logic [ADDR_W-1:0] src_addr,
    input  logic [7:0]        src_data,
    output logic              vram_we,
    output logic [VRAM_W-1:0] vram_addr,
    output logic [7:0]        vram_wdata,
    output logic              cpu_halt
);

    logic                         ctrl_we;
    logic                         busy, load, step, adv, last_byte;
    logic [LEN_W-1:0]             remaining;
    logic [ADDR_W-CHUNK_LOG2-1:0] src_base;
    logic [VRAM_W-CHUNK_LOG2-1:0] dst_base;

    assign ctrl_we = reg_we && (reg_addr == RA_CTRL);

    vbc_regs #(.ADDR_W(ADDR_W), .VRAM_W(VRAM_W), .CHUNK_LOG2(CHUNK_LOG2)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .busy(busy), .src_base(src_base), .dst_base(dst_base)
    );

    vbc_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(reg_wdata),
        .hblank_i(hblank_pulse), .disp_en_i(disp_en), .last_byte(last_byte),
        .load(load), .step(step), .adv(adv), .busy(busy), .halt(cpu_halt),
        .remaining(remaining)
    );

    vbc_ptr #(.ADDR_W(ADDR_W), .VRAM_W(VRAM_W), .CHUNK_LOG2(CHUNK_LOG2)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step), .adv(adv),
        .src_base(src_base), .dst_base(dst_base), .src_rd(src_rd), .src_addr(src_addr),
        .vram_we(vram_we), .vram_addr(vram_addr), .last_byte(last_byte)
    );

    assign vram_wdata = src_data;

    always_comb begin
        reg_rdata = 8'hFF;
        if (reg_addr == RA_CTRL) begin
            reg_rdata[7]         = ~busy;
            reg_rdata[LEN_W-1:0] = remaining;
        end
    end

    // R9
    wr_under_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vram_we |-> cpu_halt);

    // R4
    gp_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !reg_wdata[7] && !busy) |=> cpu_halt);

endmodule

// File: tb/sim_vram_blkcopy.sv
module sim_vram_blkcopy;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd4;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        hblank_pulse = 1'b0;
    logic        disp_en = 1'b1;
    logic        src_rd;
    logic [15:0] src_addr;
    logic [7:0]  src_data = 8'h00;
    logic        vram_we;
    logic [12:0] vram_addr;
    logic [7:0]  vram_wdata;
    logic        cpu_halt;

    int n_chk = 0;
    int n_err = 0;
    int wcount = 0;
    int hcount = 0;
    logic [15:0] exp_src = '0;
    logic [12:0] exp_dst = '0;
    bit done = 0;

    always #5 clk = ~clk;

    vram_blkcopy u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hblank_pulse(hblank_pulse),
        .disp_en(disp_en), .src_rd(src_rd), .src_addr(src_addr), .src_data(src_data),
        .vram_we(vram_we), .vram_addr(vram_addr), .vram_wdata(vram_wdata),
        .cpu_halt(cpu_halt)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // source memory with one cycle of read latency
    always @(posedge clk) if (src_rd) src_data <= pat(src_addr);

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // write monitor
    always @(negedge clk) begin
        if (rst_n && cpu_halt) hcount++;
        if (rst_n && vram_we) begin
            if (vram_addr != exp_dst) chk("R2 dst offset", vram_addr, exp_dst);
            if (vram_wdata != pat(exp_src)) chk("R1 src byte", vram_wdata, pat(exp_src));
            exp_src = exp_src + 16'd1;
            exp_dst = exp_dst + 13'd1;
            wcount++;
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 3'd4;
    endtask

    task automatic pulse();
        @(negedge clk); hblank_pulse = 1'b1;
        @(negedge clk); hblank_pulse = 1'b0;
    endtask

    task automatic setup(input logic [7:0] sh, input logic [7:0] sl,
                         input logic [7:0] dh, input logic [7:0] dl);
        wr_reg(3'd0, sh); wr_reg(3'd1, sl); wr_reg(3'd2, dh); wr_reg(3'd3, dl);
        exp_src = {sh, sl[7:4], 4'h0};
        exp_dst = {dh[4:0], dl[7:4], 4'h0};
        wcount = 0; hcount = 0;
    endtask

    task automatic run_gp(input logic [7:0] sh, input logic [7:0] sl,
                          input logic [7:0] dh, input logic [7:0] dl, input int n);
        setup(sh, sl, dh, dl);
        wr_reg(3'd4, {1'b0, 7'(n)});
        chk("R8 busy status", reg_rdata, {1'b0, 7'(n)});
        while (!reg_rdata[7]) @(negedge clk);
        chk("R3 byte count", wcount, (n + 1) * 16);
        chk("R4 halt cycles", hcount, (n + 1) * 17);
        chk("R8 done status", reg_rdata, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 reset status", reg_rdata, 8'hFF);
        chk("R9 reset halt", cpu_halt, 0);
        chk("R10 reset strobes", {src_rd, vram_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4: sweep of chunk counts with junk in ignored bits
        for (int n = 0; n < 32; n++)
            run_gp(8'h10 + 8'(n * 7), {4'(n), 4'hF}, 8'hE0 | 8'(n), {4'(n + 3), 4'hA}, n);
        // full length with wrap of both pointers
        run_gp(8'hFF, 8'hF0, 8'hFF, 8'hF0, 127);

        // horizontal-blank mode
        setup(8'h40, 8'h00, 8'h01, 8'h20);
        wr_reg(3'd4, 8'h82);
        chk("R8 armed status", reg_rdata, 8'h02);
        repeat (20) @(negedge clk);
        chk("R5 nothing before blank", wcount, 0);
        chk("R9 no halt while armed", hcount, 0);
        disp_en = 1'b0;
        pulse();
        repeat (30) @(negedge clk);
        chk("R6 display off ignored", wcount, 0);
        disp_en = 1'b1;
        wr_reg(3'd0, 8'h99);
        wr_reg(3'd3, 8'h70);
        wr_reg(3'd4, 8'hC5);
        chk("R11 ctrl write ignored", reg_rdata, 8'h02);
        pulse();
        repeat (30) @(negedge clk);
        chk("R5 one chunk per blank", wcount, 16);
        chk("R9 halt per chunk", hcount, 17);
        chk("R9 halt low after chunk", cpu_halt, 0);
        chk("R8 remaining after one", reg_rdata, 8'h01);
        pulse();
        repeat (30) @(negedge clk);
        chk("R11 R3 second chunk continues", wcount, 32);
        chk("R8 remaining after two", reg_rdata, 8'h00);
        wr_reg(3'd4, 8'h00);
        chk("R7 cancel status", reg_rdata, 8'h80);
        pulse();
        repeat (30) @(negedge clk);
        chk("R7 no copy after cancel", wcount, 32);

        setup(8'h05, 8'h30, 8'h1F, 8'hF0);
        wr_reg(3'd4, 8'h80);
        pulse();
        repeat (30) @(negedge clk);
        chk("R5 single chunk", wcount, 16);
        chk("R8 complete status", reg_rdata, 8'hFF);
        reg_addr = 3'd1;
        @(negedge clk);
        chk("R8 other index reads ones", reg_rdata, 8'hFF);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule